// File: doc/BRIEF.md
# Set-Associative Cache Tag Array with LRU Replacement

This block keeps the tags of a set-associative cache and decides for every presented address whether it would hit or miss. Each line slot holds a tag, a valid bit and a recency stamp. No data is stored. An address is split into three parts, from low bits to high bits: a byte offset, a set index and a tag. The tag is compared against every way of the selected set in parallel.

On a hit the matching way is refreshed. On a miss the line is installed. An empty way is used if one exists; otherwise the least recently used way is evicted. Recency comes from a free-running access counter, and each touched way copies the counter's value into its stamp. The block accepts one access per clock. The verdict and two running totals, hits and misses, are registered.

Line size, total capacity and number of ways are parameters, and the set count is derived from them. With the defaults (32 KB capacity, 64-byte lines, 8 ways) the array has 64 sets.

Top module: `cache_tag_model`

## Requirements
- R1: Reset (synchronous, active low) clears the result strobe, the hit flag, both counters and the access counter, and marks every way of every set empty, so the next access to any address misses.
- R2: With the default parameters, address bits [5:0] are a byte offset that plays no part in the lookup, bits [11:6] select one of 64 sets, and bits [31:12] form the tag. Addresses that differ only in the offset reach the same line.
- R3: An access hits when a valid way in its set holds its tag. After the clock edge that samples the access, `res_hit` is 1 and `hit_count` has grown by exactly one.
- R4: An access that does not hit gives `res_hit` = 0 after the sampling edge, raises `miss_count` by exactly one, and installs its tag in the set.
- R5: A miss fills the lowest-numbered empty way before any valid way is evicted. A set therefore holds up to the number of ways of distinct tags at once, and a tag is present in at most one way of a set.
- R6: When a set is full, a miss replaces the way whose stamp is smallest, with ties going to the lowest-numbered way. A hit writes the current access count into the way's stamp, so recently hit lines survive.
- R7: The access counter advances on every access, hit or miss, and a fill stamps the new line with the counter's value at that time.
- R8: A cycle without an access leaves both counters unchanged, and `res_valid` is 0 after the following edge.
- R9: Sets are independent: accesses to one set never change which tags another set holds.
- R10: `res_valid` is 1 after exactly those clock edges at which `acc_valid` was sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | Byte address of the access |
| res_valid | output | 1 | A result is present from the previous cycle's access |
| res_hit | output | 1 | 1 = last access hit, 0 = it missed |
| hit_count | output | 32 | Total hits since reset |
| miss_count | output | 32 | Total misses since reset |

## Verification
Every result of this block is due one edge after its access: the verdict, the strobe and both counters change at the same rising edge that samples `acc_valid`. The tag and stamp writes from that edge are visible to an access in the very next cycle. The bench changes inputs on the falling edge and reads outputs one nanosecond after the following rising edge. In this way each check sees exactly one access's effect, and back-to-back accesses to one set show that a refresh or fill is visible to its immediate successor. Replacement order is never read directly. It is inferred from later hits and misses, which are due at the same one-edge latency.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;

    localparam int ADDR_W  = 32;
    localparam int CNT_W   = 32;
    localparam int STAMP_W = 32;

    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [CNT_W-1:0]   cnt_t;
    typedef logic [STAMP_W-1:0] stamp_t;

    // Registered state of the top-level control.
    typedef struct packed {
        logic   res_valid;
        logic   res_hit;
        cnt_t   hit_cnt;
        cnt_t   miss_cnt;
        stamp_t stamp;
    } ctl_state_t;

endpackage

// File: rtl/ct_addr_split.sv
module ct_addr_split #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 6,
    parameter int IDX_W  = 6,
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);

    // Offset bits are dropped; index sits directly above them.
    assign idx = addr[OFF_W +: IDX_W];
    assign tag = addr[ADDR_W-1 -: TAG_W];

endmodule

// File: rtl/ct_tag_store.sv
module ct_tag_store #(
    parameter int SETS    = 64,
    parameter int WAYS    = 8,
    parameter int TAG_W   = 20,
    parameter int STAMP_W = 32,
    localparam int IDX_W  = $clog2(SETS),
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [IDX_W-1:0]                 rd_idx,
    output logic [WAYS-1:0]                  rd_valid,
    output logic [WAYS-1:0][TAG_W-1:0]       rd_tag,
    output logic [WAYS-1:0][STAMP_W-1:0]     rd_stamp,
    input  logic                             wr_en,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic [WAY_W-1:0]                 wr_way,
    input  logic [TAG_W-1:0]                 wr_tag,
    input  logic [STAMP_W-1:0]               wr_stamp
);

    logic [WAYS-1:0]              valid_q [SETS];
    logic [WAYS-1:0][TAG_W-1:0]   tag_q   [SETS];
    logic [WAYS-1:0][STAMP_W-1:0] stamp_q [SETS];

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_stamp = stamp_q[rd_idx];

    // Only valid bits need a reset; tag and stamp are gated by them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
            end
        end else if (wr_en) begin
            valid_q[wr_idx][wr_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx][wr_way]   <= wr_tag;
            stamp_q[wr_idx][wr_way] <= wr_stamp;
        end
    end

endmodule

// File: rtl/ct_way_lookup.sv
module ct_way_lookup #(
    parameter int WAYS    = 8,
    parameter int TAG_W   = 20,
    parameter int STAMP_W = 32,
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]              way_valid,
    input  logic [WAYS-1:0][TAG_W-1:0]   way_tag,
    input  logic [WAYS-1:0][STAMP_W-1:0] way_stamp,
    input  logic [TAG_W-1:0]             acc_tag,
    output logic [WAYS-1:0]              hit_vec,
    output logic                         hit,
    output logic [WAY_W-1:0]             tgt_way
);

    logic [WAY_W-1:0]   hit_way;
    logic               hit_found;
    logic [WAY_W-1:0]   free_way;
    logic               free_found;
    logic [WAY_W-1:0]   old_way;
    logic [STAMP_W-1:0] old_stamp;

    // Per-way tag comparators.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = way_valid[w] && (way_tag[w] == acc_tag);
    end

    assign hit = |hit_vec;

    always_comb begin
        hit_way    = '0;
        hit_found  = 1'b0;
        free_way   = '0;
        free_found = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w] && !hit_found) begin
                hit_way   = WAY_W'(w);
                hit_found = 1'b1;
            end
            if (!way_valid[w] && !free_found) begin
                free_way   = WAY_W'(w);
                free_found = 1'b1;
            end
        end
    end

    // Oldest stamp; strict compare keeps the lowest way on a tie.
    always_comb begin
        old_way   = '0;
        old_stamp = way_stamp[0];
        for (int w = 1; w < WAYS; w++) begin
            if (way_stamp[w] < old_stamp) begin
                old_way   = WAY_W'(w);
                old_stamp = way_stamp[w];
            end
        end
    end

    always_comb begin
        if (hit) begin
            tgt_way = hit_way;
        end else if (free_found) begin
            tgt_way = free_way;
        end else begin
            tgt_way = old_way;
        end
    end

endmodule

// File: rtl/cache_tag_model.sv
module cache_tag_model
    import cache_tag_pkg::*;
#(
    parameter int CACHE_BYTES = 32768,
    parameter int LINE_BYTES  = 64,
    parameter int WAYS        = 8,
    localparam int SETS       = CACHE_BYTES / LINE_BYTES / WAYS,
    localparam int OFF_W      = $clog2(LINE_BYTES),
    localparam int IDX_W      = $clog2(SETS),
    localparam int TAG_W      = ADDR_W - OFF_W - IDX_W,
    localparam int WAY_W      = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              res_valid,
    output logic              res_hit,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);

    ctl_state_t st_d, st_q;

    logic [IDX_W-1:0]             acc_idx;
    logic [TAG_W-1:0]             acc_tag;
    logic [WAYS-1:0]              row_valid;
    logic [WAYS-1:0][TAG_W-1:0]   row_tag;
    logic [WAYS-1:0][STAMP_W-1:0] row_stamp;
    logic [WAYS-1:0]              hit_vec;
    logic                         hit;
    logic [WAY_W-1:0]             tgt_way;

    ct_addr_split #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .IDX_W  (IDX_W)
    ) split_i (
        .addr (acc_addr),
        .idx  (acc_idx),
        .tag  (acc_tag)
    );

    ct_tag_store #(
        .SETS    (SETS),
        .WAYS    (WAYS),
        .TAG_W   (TAG_W),
        .STAMP_W (STAMP_W)
    ) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (acc_idx),
        .rd_valid (row_valid),
        .rd_tag   (row_tag),
        .rd_stamp (row_stamp),
        .wr_en    (acc_valid),
        .wr_idx   (acc_idx),
        .wr_way   (tgt_way),
        .wr_tag   (acc_tag),
        .wr_stamp (st_q.stamp)
    );

    ct_way_lookup #(
        .WAYS    (WAYS),
        .TAG_W   (TAG_W),
        .STAMP_W (STAMP_W)
    ) lookup_i (
        .way_valid (row_valid),
        .way_tag   (row_tag),
        .way_stamp (row_stamp),
        .acc_tag   (acc_tag),
        .hit_vec   (hit_vec),
        .hit       (hit),
        .tgt_way   (tgt_way)
    );

    always_comb begin
        st_d           = st_q;
        st_d.res_valid = acc_valid;
        if (acc_valid) begin
            st_d.res_hit = hit;
            st_d.stamp   = st_q.stamp + STAMP_W'(1);
            if (hit) begin
                st_d.hit_cnt = st_q.hit_cnt + CNT_W'(1);
            end else begin
                st_d.miss_cnt = st_q.miss_cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid  = st_q.res_valid;
    assign res_hit    = st_q.res_hit;
    assign hit_count  = st_q.hit_cnt;
    assign miss_count = st_q.miss_cnt;

endmodule

// File: rtl/cache_tag_model_chk.sv
module cache_tag_model_chk #(
    parameter int WAYS = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            acc_valid,
    input logic            res_valid,
    input logic            res_hit,
    input logic [31:0]     hit_count,
    input logic [31:0]     miss_count,
    input logic [WAYS-1:0] hit_vec
);

    AST_RES_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> res_valid); // R10

    AST_NO_RES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !res_valid); // R8

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> ($stable(hit_count) && $stable(miss_count))); // R8

    AST_HIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_hit) |->
            (hit_count == $past(hit_count) + 32'd1) && $stable(miss_count)); // R3

    AST_MISS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |->
            (miss_count == $past(miss_count) + 32'd1) && $stable(hit_count)); // R4

    AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> $onehot0(hit_vec)); // R5

endmodule

bind cache_tag_model cache_tag_model_chk #(.WAYS(WAYS)) chk_i (.*);

// File: tb/cache_tag_model_tb.sv
module cache_tag_model_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        res_valid;
    logic        res_hit;
    logic [31:0] hit_count;
    logic [31:0] miss_count;

    int checks = 0;
    int errors = 0;
    int exp_hits = 0;
    int exp_misses = 0;

    always #5 clk = ~clk;

    cache_tag_model dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (acc_valid),
        .acc_addr   (acc_addr),
        .res_valid  (res_valid),
        .res_hit    (res_hit),
        .hit_count  (hit_count),
        .miss_count (miss_count)
    );

    // Default geometry: tag [31:12], set [11:6], offset [5:0].
    function automatic logic [31:0] mk(int tag, int set, int off);
        return {tag[19:0], set[5:0], off[5:0]};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One access; result and counters checked 1 ns after the sampling edge.
    task automatic do_access(input logic [31:0] addr, input bit exp_hit, input string req);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_addr  = addr;
        @(posedge clk);
        #1;
        acc_valid = 1'b0;
        if (exp_hit) exp_hits++; else exp_misses++;
        chk(req, "res_valid", {31'b0, res_valid}, 32'd1);
        chk(req, "res_hit", {31'b0, res_hit}, {31'b0, exp_hit});
        chk(req, "hit_count", hit_count, exp_hits);
        chk(req, "miss_count", miss_count, exp_misses);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        acc_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        exp_hits = 0;
        exp_misses = 0;
        chk("R1", "res_valid", {31'b0, res_valid}, 32'd0);
        chk("R1", "res_hit", {31'b0, res_hit}, 32'd0);
        chk("R1", "hit_count", hit_count, 32'd0);
        chk("R1", "miss_count", miss_count, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R2, R3, R4: offset ignored, set and tag fields decoded.
    task automatic t_decode();
        do_access(mk(16'h11, 3, 4), 1'b0, "R4");
        do_access(mk(16'h11, 3, 60), 1'b1, "R2");
        do_access(mk(16'h11, 4, 4), 1'b0, "R2");
        do_access(mk(16'h12, 3, 0), 1'b0, "R2");
        do_access(mk(16'h11, 3, 0), 1'b1, "R3");
    endtask

    // R5: a full set keeps WAYS distinct tags.
    task automatic t_fill();
        for (int i = 0; i < 8; i++) do_access(mk(16'h500 + i, 5, 0), 1'b0, "R5");
        for (int i = 0; i < 8; i++) do_access(mk(16'h500 + i, 5, 8), 1'b1, "R5");
    endtask

    // R6: hit refreshes way; victim is the oldest stamp.
    task automatic t_lru();
        for (int i = 0; i < 8; i++) do_access(mk(16'h100 + i, 9, 0), 1'b0, "R6");
        do_access(mk(16'h100, 9, 0), 1'b1, "R6");
        do_access(mk(16'h200, 9, 0), 1'b0, "R6");
        do_access(mk(16'h100, 9, 0), 1'b1, "R6");
        do_access(mk(16'h101, 9, 0), 1'b0, "R6");
        do_access(mk(16'h200, 9, 0), 1'b1, "R6");
        do_access(mk(16'h107, 9, 0), 1'b1, "R6");
    endtask

    // R7: fills get distinct stamps, so the last-filled untouched way is the oldest.
    task automatic t_miss_stamp();
        for (int i = 0; i < 8; i++) do_access(mk(16'h300 + i, 30, 0), 1'b0, "R7");
        for (int i = 0; i < 7; i++) do_access(mk(16'h300 + i, 30, 0), 1'b1, "R7");
        do_access(mk(16'h3ff, 30, 0), 1'b0, "R7");
        do_access(mk(16'h300, 30, 0), 1'b1, "R7");
        do_access(mk(16'h307, 30, 0), 1'b0, "R7");
    endtask

    // R8: idle cycles change nothing.
    task automatic t_idle();
        @(negedge clk);
        acc_valid = 1'b0;
        acc_addr  = mk(16'h777, 1, 0);
        repeat (3) @(posedge clk);
        #1;
        chk("R8", "res_valid", {31'b0, res_valid}, 32'd0);
        chk("R8", "hit_count", hit_count, exp_hits);
        chk("R8", "miss_count", miss_count, exp_misses);
    endtask

    // R9: thrashing set 9 leaves set 5 intact.
    task automatic t_sets();
        for (int i = 0; i < 10; i++) do_access(mk(16'h900 + i, 9, 0), 1'b0, "R9");
        for (int i = 0; i < 8; i++) do_access(mk(16'h500 + i, 5, 0), 1'b1, "R9");
    endtask

    // R1: reset empties the array.
    task automatic t_reset_clears();
        t_reset();
        do_access(mk(16'h11, 3, 0), 1'b0, "R1");
        do_access(mk(16'h500, 5, 0), 1'b0, "R1");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_decode();
        t_fill();
        t_lru();
        t_miss_stamp();
        t_idle();
        t_sets();
        t_reset_clears();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule